// File: doc/BRIEF.md
# Multi-pin keyboard interrupt controller

This block watches a group of input pins and raises one interrupt line when an enabled pin changes to its active state. Each pin has its own enable bit and its own polarity bit. A polarity bit selects either falling edge and low level, or rising edge and high level. A global mode bit chooses between edge-only detection and detection of edges plus levels. The pin inputs are asynchronous. Each one passes through a two-flop synchronizer before any logic looks at it.

The synchronized pins are turned into active-high "asserted" signals. The enabled ones are ORed into a single combined line, and edges are found only on that combined line. After one edge, every enabled pin must therefore return to its idle level before another edge can count. A sticky flag records detections, and software clears it by writing a one to an acknowledge bit. In level mode the acknowledge cannot clear the flag while any enabled pin is still asserted. The interrupt request is the flag gated by an interrupt-enable bit.

Software reaches the block through a small register port. The port has an address, a write strobe, write data and combinational read data. Behind it sit three 8-bit registers: control/status, pin enable and polarity.

Top module: `keyscan_irq`

## Requirements
- R1: After reset, all three registers read 0, and `flag_o` and `irq_o` are 0.
- R2: Register offsets are fixed: 0 is control/status, 1 is pin enable, 2 is polarity, and offset 3 reads 0. In control/status, bit 0 is the level-mode select, bit 1 is the interrupt enable, bit 2 is the acknowledge (write-only, always reads 0) and bit 3 is the flag (read-only, writes ignored). Bits 7:4 read 0. Offsets 1 and 2 read back what was written.
- R3: A pin whose enable bit is 0 never sets the flag, whatever it does.
- R4: A polarity bit of 0 makes a high-to-low transition the active edge. A polarity bit of 1 makes a low-to-high transition the active edge, and the opposite transition does not set the flag.
- R5: An active edge applied between clock edges makes `flag_o` read 1 after the third rising clock edge, and not before.
- R6: Once an edge is detected, no further edge on any enabled pin sets the flag until every enabled pin has been at its deasserted level at the same time.
- R7: `irq_o` equals `flag_o` ANDed with the interrupt-enable bit.
- R8: In edge-only mode, writing 1 to the acknowledge bit clears the flag on that clock edge, even if a pin is still held asserted. The flag stays set until it is acknowledged.
- R9: In level mode, an enabled asserted pin sets the flag with no edge needed, and an acknowledge while that pin is asserted leaves the flag set.
- R10: When a flag-setting event and an acknowledge write fall in the same cycle, the flag ends up set.
- R11: Enabling a pin that is already at its asserted level sets the flag one cycle after the enable write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe, takes effect on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pins_in | input | 8 | Asynchronous pin inputs |
| flag_o | output | 1 | Sticky detection flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: eight pins, an 8-bit data path, a two-stage input synchronizer and a two-stage reset synchronizer. With these defaults every pin is a possible source, and the latency from pin to flag is a fixed three clock edges, so each test can check the exact cycle in which the flag rises. The eight pins also let the bench hold one enabled pin asserted while it drives another. This covers the shared-line re-arm rule, disabled-pin isolation and the set-over-acknowledge collision.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_PEN  = 2'd1;
  localparam logic [ADDR_W-1:0] A_POL  = 2'd2;

  localparam int unsigned B_MODE = 0;
  localparam int unsigned B_IEN  = 1;
  localparam int unsigned B_ACK  = 2;
  localparam int unsigned B_FLAG = 3;

  typedef struct packed {
    logic irq_en;
    logic lvl_mode;
  } ctrl_t;
endpackage

// File: rtl/keyscan_rst_sync.sv
module keyscan_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/keyscan_sync.sv
module keyscan_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/keyscan_regs.sv
module keyscan_regs
  import keyscan_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                we,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                flag_i,
  output logic [DATA_W-1:0]   rdata,
  output logic [NUM_PINS-1:0] pin_en,
  output logic [NUM_PINS-1:0] pin_pol,
  output logic                irq_en,
  output logic                lvl_mode,
  output logic                ack_pulse
);
  ctrl_t               ctrl_q, ctrl_d;
  logic [NUM_PINS-1:0] pen_q, pen_d;
  logic [NUM_PINS-1:0] pol_q, pol_d;
  logic                wr_ctrl, wr_pen, wr_pol;

  // write decode and next-state values
  always_comb begin
    wr_ctrl = we && (addr == A_CTRL);
    wr_pen  = we && (addr == A_PEN);
    wr_pol  = we && (addr == A_POL);
    ctrl_d.irq_en   = wdata[B_IEN];
    ctrl_d.lvl_mode = wdata[B_MODE];
    pen_d = wdata[NUM_PINS-1:0];
    pol_d = wdata[NUM_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pen_q  <= '0;
      pol_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_pen)  pen_q  <= pen_d;
      if (wr_pol)  pol_q  <= pol_d;
    end
  end

  // read path: combinational, unused bits zero
  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[B_FLAG] = flag_i;
        rdata[B_IEN]  = ctrl_q.irq_en;
        rdata[B_MODE] = ctrl_q.lvl_mode;
      end
      A_PEN:   rdata[NUM_PINS-1:0] = pen_q;
      A_POL:   rdata[NUM_PINS-1:0] = pol_q;
      default: rdata = '0;
    endcase
  end

  assign ack_pulse = wr_ctrl && wdata[B_ACK];
  assign pin_en    = pen_q;
  assign pin_pol   = pol_q;
  assign irq_en    = ctrl_q.irq_en;
  assign lvl_mode  = ctrl_q.lvl_mode;
endmodule

// File: rtl/keyscan_detect.sv
module keyscan_detect #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_sync,
  input  logic [NUM_PINS-1:0] pin_en,
  input  logic [NUM_PINS-1:0] pin_pol,
  input  logic                lvl_mode,
  input  logic                ack,
  output logic                flag,
  output logic                comb_line,
  output logic                set_evt
);
  logic [NUM_PINS-1:0] active;
  logic                line_q;
  logic                flag_q, flag_d;
  logic                edge_evt;

  // per-pin: polarity fold, then enable mask
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign active[p] = pin_en[p] & (pins_sync[p] ^ ~pin_pol[p]);
  end

  assign comb_line = |active;
  assign edge_evt  = comb_line & ~line_q;
  assign set_evt   = edge_evt | (lvl_mode & comb_line);

  always_comb begin
    flag_d = flag_q;
    if (set_evt)  flag_d = 1'b1;
    else if (ack) flag_d = 1'b0;
  end

  // line_q resets high: an asserted line at reset is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      line_q <= comb_line;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/keyscan_irq.sv
module keyscan_irq
  import keyscan_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pins_in,
  output logic                flag_o,
  output logic                irq_o
);
  logic                rst_n_int;
  logic [NUM_PINS-1:0] pins_sync;
  logic [NUM_PINS-1:0] pin_en, pin_pol;
  logic                irq_en, lvl_mode, ack_pulse;
  logic                comb_line, set_evt;

  keyscan_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_int)
  );

  keyscan_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (pins_in),
    .dout  (pins_sync)
  );

  keyscan_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .addr      (bus_addr),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .flag_i    (flag_o),
    .rdata     (bus_rdata),
    .pin_en    (pin_en),
    .pin_pol   (pin_pol),
    .irq_en    (irq_en),
    .lvl_mode  (lvl_mode),
    .ack_pulse (ack_pulse)
  );

  keyscan_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .pins_sync (pins_sync),
    .pin_en    (pin_en),
    .pin_pol   (pin_pol),
    .lvl_mode  (lvl_mode),
    .ack       (ack_pulse),
    .flag      (flag_o),
    .comb_line (comb_line),
    .set_evt   (set_evt)
  );

  assign irq_o = flag_o & irq_en;
endmodule

// File: rtl/keyscan_chk.sv
module keyscan_chk
  import keyscan_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              ack_bit,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              flag_o,
  input logic              irq_o,
  input logic              lvl_mode,
  input logic              comb_line,
  input logic              set_evt
);
  logic ack_wr;
  assign ack_wr = bus_we && (bus_addr == A_CTRL) && ack_bit;

  p_ctrl_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[DATA_W-1:4] == '0 && !bus_rdata[B_ACK]
                              && bus_rdata[B_FLAG] == flag_o));

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_o |-> !irq_o);

  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_o);

  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_evt));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !ack_wr) |=> flag_o);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !set_evt) |=> !flag_o);

  p_level_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && comb_line) |=> flag_o);

  p_set_beats_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && set_evt) |=> flag_o);
endmodule

bind keyscan_irq keyscan_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .ack_bit   (bus_wdata[keyscan_pkg::B_ACK]),
  .bus_rdata (bus_rdata),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .lvl_mode  (lvl_mode),
  .comb_line (comb_line),
  .set_evt   (set_evt)
);

// File: tb/test_keyscan_irq.sv
module test_keyscan_irq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pins_in;
  logic       flag_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyscan_irq i_keyscan_irq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd(2'd1, v); check("R1 pen", v, 8'h00);
    rd(2'd2, v); check("R1 pol", v, 8'h00);
    check("R1 flag", {7'd0, flag_o}, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(2'd0, 8'hFF); rd(2'd0, v); check("R2 ctrl bits", v, 8'h03);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hA5); rd(2'd1, v); check("R2 pen rb", v, 8'hA5);
    wr(2'd2, 8'h3C); rd(2'd2, v); check("R2 pol rb", v, 8'h3C);
    rd(2'd3, v); check("R2 unmapped", v, 8'h00);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_disabled;
    wr(2'd1, 8'h01); wr(2'd0, 8'h04);
    @(negedge clk); pins_in[5] = 1'b0;
    step(4); check("R3 disabled pin", {7'd0, flag_o}, 8'h00);
    pins_in[5] = 1'b1; step(3);
  endtask

  task automatic t_falling;
    logic [7:0] v;
    @(negedge clk); pins_in[0] = 1'b0;
    step(2); check("R5 not yet", {7'd0, flag_o}, 8'h00);
    step(1); check("R5 flag set", {7'd0, flag_o}, 8'h01);
    check("R7 irq masked", {7'd0, irq_o}, 8'h00);
    wr(2'd0, 8'h02); check("R7 irq on", {7'd0, irq_o}, 8'h01);
    rd(2'd0, v); check("R2 flag readback", v, 8'h0A);
    wr(2'd0, 8'h0A); check("R2 flag write ignored", {7'd0, flag_o}, 8'h01);
    wr(2'd0, 8'h06); check("R8 ack held pin", {7'd0, flag_o}, 8'h00);
    check("R7 irq off", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_rearm;
    wr(2'd1, 8'h03);
    @(negedge clk); pins_in[1] = 1'b0;
    step(4); check("R6 second pin blocked", {7'd0, flag_o}, 8'h00);
    pins_in[0] = 1'b1;
    step(4); check("R6 handover blocked", {7'd0, flag_o}, 8'h00);
    pins_in[1] = 1'b1; step(4);
    pins_in[1] = 1'b0;
    step(3); check("R6 rearmed", {7'd0, flag_o}, 8'h01);
    wr(2'd0, 8'h04);
    pins_in[1] = 1'b1; step(3);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_rising;
    @(negedge clk); pins_in[2] = 1'b0; step(3);
    wr(2'd2, 8'h04); wr(2'd1, 8'h04); wr(2'd0, 8'h04);
    check("R4 rising idle", {7'd0, flag_o}, 8'h00);
    @(negedge clk); pins_in[2] = 1'b1;
    step(3); check("R4 rising edge", {7'd0, flag_o}, 8'h01);
    wr(2'd0, 8'h04); check("R8 edge ack", {7'd0, flag_o}, 8'h00);
    @(negedge clk); pins_in[2] = 1'b0;
    step(4); check("R4 falling ignored", {7'd0, flag_o}, 8'h00);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    pins_in[2] = 1'b1; step(3);
  endtask

  task automatic t_level;
    wr(2'd1, 8'h01); wr(2'd0, 8'h07);
    check("R9 idle", {7'd0, flag_o}, 8'h00);
    @(negedge clk); pins_in[0] = 1'b0;
    step(3); check("R9 level set", {7'd0, flag_o}, 8'h01);
    wr(2'd0, 8'h07); check("R9 ack blocked", {7'd0, flag_o}, 8'h01);
    pins_in[0] = 1'b1; step(3);
    wr(2'd0, 8'h07); check("R9 ack after release", {7'd0, flag_o}, 8'h00);
    wr(2'd0, 8'h06);
    @(negedge clk); pins_in[0] = 1'b0; step(3);
    wr(2'd0, 8'h06); check("R8 cleared held", {7'd0, flag_o}, 8'h00);
    wr(2'd0, 8'h03); check("R9 mode latency", {7'd0, flag_o}, 8'h00);
    step(1); check("R9 level no edge", {7'd0, flag_o}, 8'h01);
    pins_in[0] = 1'b1; step(3);
    wr(2'd0, 8'h04);
  endtask

  task automatic t_collide;
    check("R10 start clear", {7'd0, flag_o}, 8'h00);
    @(negedge clk); pins_in[0] = 1'b0;
    step(2);
    bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 8'h04;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
    check("R10 set wins", {7'd0, flag_o}, 8'h01);
    pins_in[0] = 1'b1; step(3);
    wr(2'd0, 8'h04); wr(2'd1, 8'h00);
  endtask

  task automatic t_enable_asserted;
    @(negedge clk); pins_in[3] = 1'b0; step(3);
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h08); check("R11 not yet", {7'd0, flag_o}, 8'h00);
    step(1); check("R11 false flag", {7'd0, flag_o}, 8'h01);
    wr(2'd1, 8'h00); wr(2'd0, 8'h04);
    pins_in[3] = 1'b1; step(3);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pins_in = 8'hFF;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_regs();
    t_disabled();
    t_falling();
    t_rearm();
    t_rising();
    t_level();
    t_collide();
    t_enable_asserted();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule